// File: doc/BRIEF.md
# Input vertical sync controller

This block watches the incoming vertical sync of a video stream and counts line-rate strobes between successive sync pulses. From that count it decides whether the source is a 625-line (PAL) or 525-line (NTSC) signal. It also reports whether the last two complete fields matched, which later field-memory processing needs. Two fields match when they have the same line count and the same field parity.

It also regenerates an outgoing vertical sync. This is a single-cycle pulse placed a programmable number of lines after each incoming sync. The line delay comes in on a plain input. It passes through two registers that are loaded at incoming syncs, so a new value never moves the pulse within the field that is already running. Out of reset the delay is 170 lines.

The block sits in the pixel clock domain. All of its inputs are single-cycle strobes or levels already synchronous to that clock.

Top module: `vin_sync_ctrl`

## Requirements
- R1: After reset, `std_ntsc`, `fseq_ok` and `vsync_out` are 0. The delay that applies to the first field after reset is 170 lines.
- R2: The line count is cleared by `vsync_in`. At a `vsync_in` that closes a complete field, `std_ntsc` updates in the next cycle: 1 (NTSC) if the field had 287 lines or fewer, 0 (PAL) if it had 288 or more. The first `vsync_in` after reset leaves `std_ntsc` unchanged, and so does every cycle without `vsync_in`.
- R3: At a `vsync_in` that closes a complete field, `fseq_ok` becomes 1 when that field's line count and parity equal those of the previous complete field. Otherwise it becomes 0. Parity is the `field_par` value in the cycle of the closing `vsync_in`. Between syncs, `fseq_ok` holds its value.
- R4: `fseq_ok` stays 0 until two complete fields have been seen after reset.
- R5: The line count saturates at 1023. A field that reaches 1023 is classified as PAL and sets `fseq_ok` to 0, even if the previous field was also saturated.
- R6: `vsync_out` is high for exactly one cycle. That cycle follows the `line_stb` that brings the post-sync line count to the field's delay D.
- R7: `dly_val` is sampled at each `vsync_in`. The sampled value becomes D for the field that starts at the following `vsync_in`. Changing `dly_val` in the middle of a field does not move the pulse of the current field or of the next one.
- R8: If `vsync_in` arrives before the count reaches D, that field produces no pulse. Counting restarts from 0, and the pulse appears at D lines into the new field.
- R9: There is no pulse when D is 0, and no pulse before the first `vsync_in` after reset.
- R10: A `line_stb` that coincides with `vsync_in` is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle strobe per line |
| vsync_in | input | 1 | One-cycle incoming vertical sync |
| field_par | input | 1 | Field parity, sampled with `vsync_in` |
| dly_val | input | 8 | Line delay for the outgoing sync |
| std_ntsc | output | 1 | 1 = NTSC, 0 = PAL |
| fseq_ok | output | 1 | Last two complete fields matched |
| vsync_out | output | 1 | Regenerated vertical sync pulse |

## Verification
Some properties are checked on every cycle by the assertions:
- the single-cycle width of the outgoing pulse;
- that it only follows a line strobe;
- that it is never issued directly after a sync, with a zero delay, or before the first sync;
- that both status flags change only after an incoming sync.

Other behaviour depends on how many lines were counted, so only the bench scenarios show it:
- where the pulse lands in the field;
- the 287/288 classification boundary;
- parity-sensitive field matching;
- the two-field delay pipeline;
- saturation at 1023;
- a strobe that coincides with a sync not being counted.

// File: rtl/vin_sync_ctrl.sv
module vin_sync_ctrl #(
  parameter int CNT_W   = 10,
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 170,
  parameter int PAL_MIN = 288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic             vsync_in,
  input  logic             field_par,
  input  logic [DLY_W-1:0] dly_val,
  output logic             std_ntsc,
  output logic             fseq_ok,
  output logic             vsync_out
);

  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] PAL_MIN_L = PAL_MIN[CNT_W-1:0];
  localparam logic [DLY_W-1:0] DLY_RST_L = DLY_RST[DLY_W-1:0];

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] prev_cnt;
  logic             prev_par;
  logic             prev_ok;
  logic             seen;
  logic [DLY_W-1:0] nxt_dly;
  logic [DLY_W-1:0] cur_dly;
  logic [CNT_W:0]   cnt_inc;
  logic             sat;
  logic             hit;

  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign sat     = (cnt == CNT_MAX);
  assign hit     = seen && line_stb && (cur_dly != '0) &&
                   (cnt_inc == {{(CNT_W+1-DLY_W){1'b0}}, cur_dly});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      prev_cnt  <= '0;
      prev_par  <= 1'b0;
      prev_ok   <= 1'b0;
      seen      <= 1'b0;
      nxt_dly   <= DLY_RST_L;
      cur_dly   <= DLY_RST_L;
      std_ntsc  <= 1'b0;
      fseq_ok   <= 1'b0;
      vsync_out <= 1'b0;
    end else if (vsync_in) begin
      if (seen) begin
        std_ntsc <= (cnt < PAL_MIN_L);
        fseq_ok  <= prev_ok && !sat && (cnt == prev_cnt) && (field_par == prev_par);
        prev_cnt <= cnt;
        prev_par <= field_par;
        prev_ok  <= 1'b1;
      end
      cnt       <= '0;
      seen      <= 1'b1;
      cur_dly   <= nxt_dly;
      nxt_dly   <= dly_val;
      vsync_out <= 1'b0;
    end else begin
      if (line_stb && !sat) cnt <= cnt_inc[CNT_W-1:0];
      vsync_out <= hit;
    end
  end

endmodule

// File: rtl/vin_sync_ctrl_chk.sv
module vin_sync_ctrl_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_stb,
  input logic             vsync_in,
  input logic             std_ntsc,
  input logic             fseq_ok,
  input logic             vsync_out,
  input logic [DLY_W-1:0] cur_dly,
  input logic             seen
);

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out |=> !vsync_out);

  p_pulse_on_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out |-> $past(line_stb));

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vsync_in) |-> !vsync_out);

  p_std_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vsync_in) |-> $stable(std_ntsc));

  p_fseq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vsync_in) |-> $stable(fseq_ok));

  p_zero_dly_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out |-> (cur_dly != '0) && seen);

endmodule

bind vin_sync_ctrl vin_sync_ctrl_chk #(.DLY_W(DLY_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_stb  (line_stb),
  .vsync_in  (vsync_in),
  .std_ntsc  (std_ntsc),
  .fseq_ok   (fseq_ok),
  .vsync_out (vsync_out),
  .cur_dly   (cur_dly),
  .seen      (seen)
);

// File: tb/vin_sync_ctrl_tb_top.sv
module vin_sync_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0;
  logic       vsync_in = 1'b0;
  logic       field_par = 1'b0;
  logic [7:0] dly_val = 8'd40;
  logic       std_ntsc, fseq_ok, vsync_out;

  int checks = 0;
  int errs = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vin_sync_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync_in(vsync_in),
    .field_par(field_par), .dly_val(dly_val),
    .std_ntsc(std_ntsc), .fseq_ok(fseq_ok), .vsync_out(vsync_out)
  );

  // behavioural reference model
  int m_cnt, m_hcnt, m_cur, m_nxt;
  bit m_seen, m_hok, m_hpar, m_std, m_fseq, m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hcnt = 0; m_hpar = 0; m_hok = 0; m_seen = 0;
      m_cur = 170; m_nxt = 170; m_std = 0; m_fseq = 0; m_out = 0;
    end else if (vsync_in) begin
      if (m_seen) begin
        m_std  = (m_cnt < 288);
        m_fseq = m_hok && (m_cnt == m_hcnt) && (field_par == m_hpar) && (m_cnt != 1023);
        m_hcnt = m_cnt; m_hpar = field_par; m_hok = 1;
      end
      m_cur = m_nxt; m_nxt = int'(dly_val);
      m_cnt = 0; m_seen = 1; m_out = 0;
    end else begin
      m_out = 0;
      if (line_stb) begin
        if (m_cnt < 1023) m_cnt++;
        if (m_seen && m_cur != 0 && m_cnt == m_cur) m_out = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 3;
      if (std_ntsc !== m_std) begin
        errs++; $display("FAIL R2 std_ntsc actual=%0b expected=%0b t=%0t", std_ntsc, m_std, $time);
      end
      if (fseq_ok !== m_fseq) begin
        errs++; $display("FAIL R3 fseq_ok actual=%0b expected=%0b t=%0t", fseq_ok, m_fseq, $time);
      end
      if (vsync_out !== m_out) begin
        errs++; $display("FAIL R6 vsync_out actual=%0b expected=%0b t=%0t", vsync_out, m_out, $time);
      end
      if (vsync_out) pulses++;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic vs(input logic par);
    @(negedge clk); vsync_in = 1'b1; field_par = par;
    @(negedge clk); vsync_in = 1'b0;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_stb = 1'b1;
      @(negedge clk); line_stb = 1'b0;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 std", std_ntsc, 1'b0);
    chk("R1 fseq", fseq_ok, 1'b0);
    chk("R1 vout", vsync_out, 1'b0);
    lines(175);
    chk("R9 no pulse before first sync", logic'(pulses == 0), 1'b1);

    vs(0);                                   // field 1, D = 170 (reset default)
    chk("R2 first sync no update", std_ntsc, 1'b0);
    lines(169);
    chk("R1 not yet", vsync_out, 1'b0);
    lines(1);
    chk("R1 default delay 170", vsync_out, 1'b1);
    @(negedge clk);
    chk("R6 one cycle", vsync_out, 1'b0);
    lines(200);                              // 370 lines

    vs(1);                                   // field 2, D = 40
    chk("R2 370 PAL", std_ntsc, 1'b0);
    chk("R4 one field only", fseq_ok, 1'b0);
    lines(40);
    chk("R6 pulse at 40", vsync_out, 1'b1);
    dly_val = 8'd60;
    lines(300);                              // 340

    vs(1);                                   // field 3, D still 40
    lines(40);
    chk("R7 mid-field change not yet", vsync_out, 1'b1);
    lines(300);                              // 340

    vs(1);
    chk("R3 match", fseq_ok, 1'b1);          // field 4, D = 60
    lines(60);
    chk("R7 new delay applied", vsync_out, 1'b1);
    lines(200);                              // 260

    vs(1);
    chk("R2 260 NTSC", std_ntsc, 1'b1);
    chk("R3 count differs", fseq_ok, 1'b0);
    lines(260);
    vs(0);
    chk("R3 parity differs", fseq_ok, 1'b0);
    lines(260);
    vs(0);
    chk("R3 match again", fseq_ok, 1'b1);
    lines(287);
    vs(0);
    chk("R2 287 NTSC", std_ntsc, 1'b1);
    lines(288);
    vs(0);
    chk("R2 288 PAL", std_ntsc, 1'b0);

    p0 = pulses;
    lines(30);                               // shorter than D = 60
    vs(0);
    chk("R8 no pulse in short field", logic'(pulses == p0), 1'b1);
    lines(60);
    chk("R8 restart count", vsync_out, 1'b1);
    lines(40);                               // 100

    @(negedge clk); vsync_in = 1'b1; line_stb = 1'b1;
    @(negedge clk); vsync_in = 1'b0; line_stb = 1'b0;
    lines(287);
    vs(0);
    chk("R10 coincident strobe ignored", std_ntsc, 1'b1);

    dly_val = 8'd0;
    lines(100);
    vs(0);
    lines(100);
    vs(0);                                   // this field has D = 0
    p0 = pulses;
    lines(300);
    chk("R9 zero delay no pulse", logic'(pulses == p0), 1'b1);
    vs(0);
    dly_val = 8'd20;
    lines(1100);
    vs(0);
    chk("R5 saturated PAL", std_ntsc, 1'b0);
    chk("R5 saturated fseq", fseq_ok, 1'b0);
    lines(1100);
    vs(0);
    chk("R5 twice saturated fseq", fseq_ok, 1'b0);
    lines(10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule